// File: doc/BRIEF.md
# Set/Clear GPIO Bank Controller

This block holds the pad configuration of one bank of general-purpose pins. Each per-pin attribute lives in a state vector. Software never writes that vector directly. It writes a mask to a set port or to a clear port. Bits written as 1 act on their pins, and bits written as 0 leave their pins unchanged. Because of this, several agents can change different pins without a read-modify-write race. The current value of each vector can be read from a separate status address.

The peripheral function select, the schmitt-trigger disable and the two-bit drive strength are ordinary read/write registers. A pin whose GPIO-enable bit is 1 is driven by its own output-enable and data bits. A pin whose GPIO-enable bit is 0 takes its output and output enable from one of four peripheral functions, chosen by two select bits. The attribute vectors go out unchanged to the pad ring.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, GPIO enable and pull-up read all ones. Output enable, output data, pull-down, multi-drive, filter, interrupt enable, both select registers, schmitt disable and both drive registers read zero.
- R2: The bus address is {attr[4:2], op[1:0]} when bit 5 is 0. The attr codes are: 0 GPIO enable, 1 output enable, 2 output data, 3 pull-up, 4 pull-down, 5 multi-drive, 6 input filter, 7 interrupt enable. A write to op 0 (set) sets every written 1 bit of that attribute and leaves the 0 bits unchanged.
- R3: A write to op 1 (clear) clears every written 1 bit of that attribute and leaves the 0 bits unchanged.
- R4: A read of op 2 returns the attribute's state vector. A read of op 0, op 1 or op 3, or of an unmapped address at 0x25 and above, returns zero. Read data is combinational from the address.
- R5: Pull-up and pull-down are never both set on one pin. A set of pull-up clears pull-down on the written pins, and a set of pull-down clears pull-up on them.
- R6: Addresses 0x20 (select low) and 0x21 (select high) are read/write. The function of pin p is func_sel[2p+1:2p] = {select high[p], select low[p]}: 00 is function 0, 01 function 1, 10 function 2, 11 function 3.
- R7: Addresses 0x23 and 0x24 hold drive strength. Pins 0 to 15 use 0x23 at bits 2p+1:2p. Pins 16 to 31 use 0x24 at bits 2(p-16)+1:2(p-16). drive[2p+1:2p] is the field of pin p.
- R8: When GPIO enable of a pin is 1, pad_oe equals its output-enable bit and pad_out equals its output-data bit, whatever the function inputs are.
- R9: When GPIO enable of a pin is 0, pad_out and pad_oe equal fn_out[f*32+p] and fn_oe[f*32+p], where f is the pin's selected function.
- R10: Address 0x22 is a read/write schmitt-disable register, and its value drives schmitt_off. A 1 turns the trigger off on that pin.
- R11: The gpio_mode, pull_up, pull_down, multi_drive, filter_en and irq_en outputs always equal the matching state vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 32 | Write data or mask |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data for bus_addr |
| fn_out | input | 128 | Peripheral output values, function-major |
| fn_oe | input | 128 | Peripheral output enables, function-major |
| pad_out | output | 32 | Value to pad |
| pad_oe | output | 32 | Output enable to pad |
| gpio_mode | output | 32 | GPIO enable state |
| pull_up | output | 32 | Pull-up enables |
| pull_down | output | 32 | Pull-down enables |
| multi_drive | output | 32 | Open-drain enables |
| filter_en | output | 32 | Input glitch filter enables |
| irq_en | output | 32 | Per-pin interrupt enables |
| schmitt_off | output | 32 | Schmitt-trigger disables |
| func_sel | output | 64 | Two-bit function choice per pin |
| drive | output | 64 | Two-bit drive strength per pin |

## Verification
Each attribute vector goes straight to a port, so a wrong bit in any state register shows in the same cycle after the write that caused it. The same bit also shows at once on the status read of that register. A wrong pad multiplexer or a wrong select decode shows on pad_out or pad_oe as soon as the function inputs differ between functions. The bench changes those inputs every cycle, so such a fault shows within a cycle or two. A missed pull cross-clear leaves both pull bits high and shows on the next comparison.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int unsigned ADDR_W   = 6;
    localparam int unsigned NUM_ATTR = 8;
    localparam int unsigned NFUNC    = 4;

    typedef enum logic [2:0] {
        ATTR_PIO  = 3'd0,
        ATTR_OE   = 3'd1,
        ATTR_DATA = 3'd2,
        ATTR_PU   = 3'd3,
        ATTR_PD   = 3'd4,
        ATTR_MD   = 3'd5,
        ATTR_FILT = 3'd6,
        ATTR_IRQ  = 3'd7
    } attr_e;

    typedef enum logic [1:0] {
        OP_SET  = 2'd0,
        OP_CLR  = 2'd1,
        OP_STAT = 2'd2,
        OP_NONE = 2'd3
    } op_e;

    typedef enum logic [4:0] {
        PL_SEL_LO  = 5'd0,
        PL_SEL_HI  = 5'd1,
        PL_SCHMITT = 5'd2,
        PL_DRV_LO  = 5'd3,
        PL_DRV_HI  = 5'd4
    } plain_e;

    // attributes that come out of reset with every bit set
    function automatic logic attr_reset_ones(int a);
        return (a == int'(ATTR_PIO)) || (a == int'(ATTR_PU));
    endfunction
endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
    parameter int unsigned W        = 32,
    parameter bit          RST_ONES = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_d, q_q;

    // clear takes precedence over set on the same bit
    always_comb begin
        q_d = (q_q | set_i) & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= RST_ONES ? {W{1'b1}} : {W{1'b0}};
        else        q_q <= q_d;
    end

    assign q_o = q_q;

    p_set_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0 && clr_i == '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

    p_clr_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((q_o & $past(clr_i)) == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPINS-1:0]       gpio_en,
    input  logic [NPINS-1:0]       oe,
    input  logic [NPINS-1:0]       odata,
    input  logic [NPINS-1:0]       sel_lo,
    input  logic [NPINS-1:0]       sel_hi,
    input  logic [NFUNC*NPINS-1:0] fn_out,
    input  logic [NFUNC*NPINS-1:0] fn_oe,
    output logic [NPINS-1:0]       pad_out,
    output logic [NPINS-1:0]       pad_oe,
    output logic [2*NPINS-1:0]     func_sel
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [1:0]       fsel;
        logic [NFUNC-1:0] po, pe;
        assign fsel = {sel_hi[p], sel_lo[p]};
        for (genvar k = 0; k < NFUNC; k++) begin : g_fn
            assign po[k] = fn_out[k*NPINS + p];
            assign pe[k] = fn_oe[k*NPINS + p];
        end
        assign func_sel[2*p +: 2] = fsel;
        assign pad_out[p] = gpio_en[p] ? odata[p] : po[fsel];
        assign pad_oe[p]  = gpio_en[p] ? oe[p]    : pe[fsel];
    end

    // a GPIO pin with its output disabled never drives the pad
    p_gpio_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_en & ~oe & pad_oe) == '0);
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [NPINS-1:0]       bus_wdata,
    input  logic                   bus_we,
    output logic [NPINS-1:0]       bus_rdata,
    input  logic [NFUNC*NPINS-1:0] fn_out,
    input  logic [NFUNC*NPINS-1:0] fn_oe,
    output logic [NPINS-1:0]       pad_out,
    output logic [NPINS-1:0]       pad_oe,
    output logic [NPINS-1:0]       gpio_mode,
    output logic [NPINS-1:0]       pull_up,
    output logic [NPINS-1:0]       pull_down,
    output logic [NPINS-1:0]       multi_drive,
    output logic [NPINS-1:0]       filter_en,
    output logic [NPINS-1:0]       irq_en,
    output logic [NPINS-1:0]       schmitt_off,
    output logic [2*NPINS-1:0]     func_sel,
    output logic [2*NPINS-1:0]     drive
);
    localparam int unsigned HALF = NPINS / 2;
    localparam int unsigned DRW  = 2 * HALF;

    typedef struct packed {
        logic [NPINS-1:0] sel_lo;
        logic [NPINS-1:0] sel_hi;
        logic [NPINS-1:0] schmitt;
        logic [DRW-1:0]   drv_lo;
        logic [DRW-1:0]   drv_hi;
    } plain_t;

    logic        is_attr;
    logic [2:0]  w_attr;
    op_e         w_op;
    plain_e      w_plain;

    assign is_attr = ~bus_addr[ADDR_W-1];
    assign w_attr  = bus_addr[4:2];
    assign w_op    = op_e'(bus_addr[1:0]);
    assign w_plain = plain_e'(bus_addr[4:0]);

    logic [NPINS-1:0] set_raw [NUM_ATTR];
    logic [NPINS-1:0] clr_raw [NUM_ATTR];
    logic [NPINS-1:0] set_eff [NUM_ATTR];
    logic [NPINS-1:0] clr_eff [NUM_ATTR];
    logic [NPINS-1:0] st      [NUM_ATTR];

    always_comb begin
        for (int a = 0; a < NUM_ATTR; a++) begin
            set_raw[a] = (bus_we && is_attr && w_attr == 3'(a) && w_op == OP_SET) ? bus_wdata : '0;
            clr_raw[a] = (bus_we && is_attr && w_attr == 3'(a) && w_op == OP_CLR) ? bus_wdata : '0;
            set_eff[a] = set_raw[a];
            clr_eff[a] = clr_raw[a];
        end
        // enabling one pull direction drops the other on the same pins
        clr_eff[int'(ATTR_PU)] = clr_raw[int'(ATTR_PU)] | set_raw[int'(ATTR_PD)];
        clr_eff[int'(ATTR_PD)] = clr_raw[int'(ATTR_PD)] | set_raw[int'(ATTR_PU)];
    end

    for (genvar g = 0; g < NUM_ATTR; g++) begin : g_attr
        gpio_setclr_reg #(
            .W        (NPINS),
            .RST_ONES (attr_reset_ones(g))
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_eff[g]),
            .clr_i (clr_eff[g]),
            .q_o   (st[g])
        );
    end

    plain_t pl_d, pl_q;

    always_comb begin
        pl_d = pl_q;
        if (bus_we && !is_attr) begin
            case (w_plain)
                PL_SEL_LO:  pl_d.sel_lo  = bus_wdata;
                PL_SEL_HI:  pl_d.sel_hi  = bus_wdata;
                PL_SCHMITT: pl_d.schmitt = bus_wdata;
                PL_DRV_LO:  pl_d.drv_lo  = bus_wdata[DRW-1:0];
                PL_DRV_HI:  pl_d.drv_hi  = bus_wdata[DRW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pl_q <= '0;
        else        pl_q <= pl_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (is_attr) begin
            if (w_op == OP_STAT) bus_rdata = st[w_attr];
        end else begin
            case (w_plain)
                PL_SEL_LO:  bus_rdata = pl_q.sel_lo;
                PL_SEL_HI:  bus_rdata = pl_q.sel_hi;
                PL_SCHMITT: bus_rdata = pl_q.schmitt;
                PL_DRV_LO:  bus_rdata[DRW-1:0] = pl_q.drv_lo;
                PL_DRV_HI:  bus_rdata[DRW-1:0] = pl_q.drv_hi;
                default: ;
            endcase
        end
    end

    assign gpio_mode   = st[int'(ATTR_PIO)];
    assign pull_up     = st[int'(ATTR_PU)];
    assign pull_down   = st[int'(ATTR_PD)];
    assign multi_drive = st[int'(ATTR_MD)];
    assign filter_en   = st[int'(ATTR_FILT)];
    assign irq_en      = st[int'(ATTR_IRQ)];
    assign schmitt_off = pl_q.schmitt;
    // low half of the pins sits in the first drive register
    assign drive       = {pl_q.drv_hi, pl_q.drv_lo};

    gpio_pad_mux #(.NPINS(NPINS)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .gpio_en  (st[int'(ATTR_PIO)]),
        .oe       (st[int'(ATTR_OE)]),
        .odata    (st[int'(ATTR_DATA)]),
        .sel_lo   (pl_q.sel_lo),
        .sel_hi   (pl_q.sel_hi),
        .fn_out   (fn_out),
        .fn_oe    (fn_oe),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .func_sel (func_sel)
    );

    p_pull_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_up & pull_down) == '0);

    p_port_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_attr && bus_addr[1:0] != 2'd2) |-> bus_rdata == '0);

    p_sel_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 6'h20) |=> func_sel[0] == $past(bus_wdata[0]));
endmodule

// File: tb/tb_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_bank_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [5:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_rdata;
    logic [127:0] fn_out = '0;
    logic [127:0] fn_oe = '0;
    logic [31:0]  pad_out, pad_oe, gpio_mode, pull_up, pull_down;
    logic [31:0]  multi_drive, filter_en, irq_en, schmitt_off;
    logic [63:0]  func_sel, drive;

    int checks = 0;
    int fails  = 0;
    bit started = 1'b0;

    always #2.5 clk = ~clk;

    gpio_bank_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .fn_out(fn_out), .fn_oe(fn_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .gpio_mode(gpio_mode),
        .pull_up(pull_up), .pull_down(pull_down), .multi_drive(multi_drive),
        .filter_en(filter_en), .irq_en(irq_en), .schmitt_off(schmitt_off),
        .func_sel(func_sel), .drive(drive)
    );

    // behavioural reference state
    logic [31:0] m_st [8];
    logic [31:0] m_sel_lo, m_sel_hi, m_sch, m_dlo, m_dhi;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_st[i] = 32'h0;
            m_st[0] = 32'hFFFF_FFFF;
            m_st[3] = 32'hFFFF_FFFF;
            m_sel_lo = 0; m_sel_hi = 0; m_sch = 0; m_dlo = 0; m_dhi = 0;
        end else if (bus_we) begin
            if (bus_addr < 6'd32) begin
                if (bus_addr[1:0] == 2'd0) begin
                    m_st[bus_addr[4:2]] = m_st[bus_addr[4:2]] | bus_wdata;
                    if (bus_addr[4:2] == 3'd3) m_st[4] = m_st[4] & ~bus_wdata;
                    if (bus_addr[4:2] == 3'd4) m_st[3] = m_st[3] & ~bus_wdata;
                end else if (bus_addr[1:0] == 2'd1) begin
                    m_st[bus_addr[4:2]] = m_st[bus_addr[4:2]] & ~bus_wdata;
                end
            end else begin
                case (bus_addr)
                    6'h20: m_sel_lo = bus_wdata;
                    6'h21: m_sel_hi = bus_wdata;
                    6'h22: m_sch    = bus_wdata;
                    6'h23: m_dlo    = bus_wdata;
                    6'h24: m_dhi    = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] m_read(logic [5:0] a);
        if (a < 6'd32) return (a[1:0] == 2'd2) ? m_st[a[4:2]] : 32'h0;
        case (a)
            6'h20: return m_sel_lo;
            6'h21: return m_sel_hi;
            6'h22: return m_sch;
            6'h23: return m_dlo;
            6'h24: return m_dhi;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every output against the model shortly after each edge
    always @(posedge clk) begin
        #2;
        if (started) begin
            logic [31:0] e_out, e_oe;
            logic [63:0] e_fs, e_dr;
            for (int p = 0; p < 32; p++) begin
                int f;
                f = {m_sel_hi[p], m_sel_lo[p]};
                e_fs[2*p +: 2] = f[1:0];
                e_dr[2*p +: 2] = (p < 16) ? m_dlo[2*p +: 2] : m_dhi[2*(p-16) +: 2];
                if (m_st[0][p]) begin
                    e_out[p] = m_st[2][p];
                    e_oe[p]  = m_st[1][p];
                end else begin
                    e_out[p] = fn_out[f*32 + p];
                    e_oe[p]  = fn_oe[f*32 + p];
                end
            end
            if (bus_addr < 6'd32 && bus_addr[1:0] == 2'd2)
                chk("R2 R3 status read", bus_rdata, m_read(bus_addr));
            else if (bus_addr < 6'd32)
                chk("R4 port reads zero", bus_rdata, m_read(bus_addr));
            else
                chk("R4 R6 R7 R10 plain read", bus_rdata, m_read(bus_addr));
            chk("R8 R9 pad_out", pad_out, e_out);
            chk("R8 R9 pad_oe", pad_oe, e_oe);
            chk("R11 gpio_mode", gpio_mode, m_st[0]);
            chk("R5 R11 pull_up", pull_up, m_st[3]);
            chk("R5 R11 pull_down", pull_down, m_st[4]);
            chk("R11 multi_drive", multi_drive, m_st[5]);
            chk("R11 filter_en", filter_en, m_st[6]);
            chk("R11 irq_en", irq_en, m_st[7]);
            chk("R10 schmitt_off", schmitt_off, m_sch);
            chk("R6 func_sel", func_sel, e_fs);
            chk("R7 drive", drive, e_dr);
        end
    end

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_expect(string tag, logic [5:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        started = 1'b1;
        // R1 reset values
        rd_expect("R1 gpio enable", 6'h02, 32'hFFFF_FFFF);
        rd_expect("R1 pull-up", 6'h0E, 32'hFFFF_FFFF);
        rd_expect("R1 output enable", 6'h06, 32'h0);
        rd_expect("R1 pull-down", 6'h12, 32'h0);
        rd_expect("R1 select high", 6'h21, 32'h0);
        rd_expect("R1 drive high", 6'h24, 32'h0);
        // R2 R3 output data set/clear with untouched bits
        wr(6'h08, 32'h0000_00F0);
        wr(6'h08, 32'h0000_0003);
        rd_expect("R2 data set keeps others", 6'h0A, 32'h0000_00F3);
        wr(6'h09, 32'h0000_0030);
        rd_expect("R3 data clear keeps others", 6'h0A, 32'h0000_00C3);
        rd_expect("R4 set port reads zero", 6'h08, 32'h0);
        rd_expect("R4 unmapped reads zero", 6'h27, 32'h0);
        // R8 gpio drive
        wr(6'h04, 32'h0000_0041);
        @(negedge clk); #1;
        chk("R8 pad_oe from oe", {96'h0, pad_oe}, {96'h0, 32'h0000_0041});
        chk("R8 pad_out from data", {96'h0, pad_out}, {96'h0, 32'h0000_00C3});
        // R5 pull exclusion
        wr(6'h10, 32'h0000_FF00);
        rd_expect("R5 pull-down set clears pull-up", 6'h0E, 32'hFFFF_00FF);
        wr(6'h0C, 32'h0000_0F00);
        rd_expect("R5 pull-up set clears pull-down", 6'h12, 32'h0000_F000);
        // R6 R9 peripheral function on pin 5 = function 2
        fn_out = 128'h0;
        fn_out[2*32 + 5] = 1'b1;
        fn_oe[2*32 + 5] = 1'b1;
        wr(6'h21, 32'h0000_0020);
        wr(6'h01, 32'h0000_0020);
        @(negedge clk); #1;
        chk("R6 pin5 function 2", {126'h0, func_sel[11:10]}, {126'h0, 2'b10});
        chk("R9 pin5 peripheral out", {127'h0, pad_out[5]}, 128'h1);
        chk("R9 pin5 peripheral oe", {127'h0, pad_oe[5]}, 128'h1);
        // R7 drive split
        wr(6'h24, 32'h0000_0002);
        wr(6'h23, 32'hC000_0000);
        @(negedge clk); #1;
        chk("R7 pin16 drive", {126'h0, drive[33:32]}, {126'h0, 2'b10});
        chk("R7 pin15 drive", {126'h0, drive[31:30]}, {126'h0, 2'b11});
        // R10 schmitt
        wr(6'h22, 32'h8000_0001);
        rd_expect("R10 schmitt readback", 6'h22, 32'h8000_0001);
        // mixed traffic for every requirement, compared each cycle
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            bus_addr  = 6'($urandom_range(0, 39));
            bus_wdata = $urandom;
            bus_we    = 1'($urandom_range(0, 1));
            fn_out    = {$urandom, $urandom, $urandom, $urandom};
            fn_oe     = {$urandom, $urandom, $urandom, $urandom};
        end
        @(negedge clk);
        bus_we = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule